// File: doc/BRIEF.md
# Non-Greedy Binary Tree Arbiter

This block picks one winner among `N` request lines and holds that choice until the winner lets go. Internally it is a binary tree of `N-1` two-input cells. Each cell passes an accepted request from either daughter up to its parent. It also routes a grant coming down from the parent to exactly one daughter, using its own one-bit alternation. At the top, the root's outgoing request is looped straight back as the root's grant. The block serves both the row selection and the column selection of an event transmitter, with one instance for each.

Every cell registers its upward request, so a request climbs one tree level per clock. The grant path back down is combinational: it is gated at every cell by the owning daughter's request. A withdrawn request therefore loses its grant in the same cycle. The tree then unwinds one level per clock.

The arbiter is non-greedy. A cell admits a new daughter request only while its own incoming grant is low. A subtree can therefore never be granted twice within one cycle of the level above it: the release has to travel all the way to the root before any new grant is issued.

Top module: `ntree_arb`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle.
- R2: A bit of `gnt_o` is high only while the same bit of `req_i` is high.
- R3: Once a leaf holds the grant, that grant stays on the same leaf, and `busy_o` stays high, for as long as that leaf's request stays high.
- R4: When the granted leaf drops its request, its `gnt_o` bit goes low in the same cycle. `busy_o` goes low exactly log2(N) clock edges later.
- R5: From idle, a single request is granted, and `busy_o` rises, exactly log2(N) clock edges after the request is first sampled.
- R6: When both daughters of a cell request in the same admission cycle, the cell picks the side it did not pick for its last grant. After reset, the first tie goes to the lower-index side, which holds leaves with smaller indices.
- R7: Non-greedy: a leaf grant can rise only in a cycle where `busy_o` rises from low. With leaves 0 and 1 (siblings) and leaf 4 all contending, leaf 4 takes every second grant, in the order 0,4,1,4,0,4,1,4 after reset.
- R8: While `rst_ni` is low, `gnt_o` is all zeros and `busy_o` is low.
- R9: `busy_o` is high in every cycle in which any bit of `gnt_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request lines, one per leaf |
| gnt_o | output | N | One-hot grant, held while the request stays high |
| busy_o | output | 1 | Root request; high while a grant is active or still unwinding |

## Verification
Two functions can land in the same cycle. One is the release of a granted leaf. The other is the readmission of a contender in a cell whose incoming grant has just been masked off. These two race inside the tree. The bench provokes the race by dropping the winner's request for exactly one clock and then raising it again while other leaves keep requesting. This places the returning request in the lower cells while the release is still climbing to the root. The bench judges the outcome by the exact order of winners (alternating pairs, and a third leaf taking every second grant) and by requiring that every fresh grant coincides with `busy_o` rising from low.

// File: rtl/ntree_arb_pkg.sv
package ntree_arb_pkg;

  typedef enum logic {
    SIDE_LO = 1'b0,
    SIDE_HI = 1'b1
  } side_e;

  function automatic side_e pick_side(logic lo, logic hi, side_e last);
    if (lo && hi) return (last == SIDE_LO) ? SIDE_HI : SIDE_LO;
    if (hi)       return SIDE_HI;
    return SIDE_LO;
  endfunction

endpackage

// File: rtl/ntree_cell.sv
module ntree_cell
  import ntree_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_lo_i,
  input  logic req_hi_i,
  input  logic gnt_i,
  output logic req_o,
  output logic gnt_lo_o,
  output logic gnt_hi_o
);

  side_e owner_q, last_q;
  logic  up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= SIDE_LO;
      last_q  <= SIDE_HI;
      up_q    <= 1'b0;
    end else if (!gnt_i) begin
      // admission window: only while nothing is granted from above
      owner_q <= pick_side(req_lo_i, req_hi_i, last_q);
      up_q    <= req_lo_i | req_hi_i;
    end else begin
      // owner frozen; follow the owning daughter until it lets go
      last_q  <= owner_q;
      up_q    <= (owner_q == SIDE_LO) ? req_lo_i : req_hi_i;
    end
  end

  assign req_o    = up_q;
  assign gnt_lo_o = gnt_i & (owner_q == SIDE_LO) & req_lo_i;
  assign gnt_hi_o = gnt_i & (owner_q == SIDE_HI) & req_hi_i;

  // R7: a cell's request may only rise out of an admission window
  assert_no_admit_under_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !$past(gnt_i));

endmodule

// File: rtl/ntree_arb.sv
module ntree_arb #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         busy_o
);

  localparam int NODES = 2 * N - 1;

  // heap numbering: node 1 is the root, cell i has daughters 2i and 2i+1,
  // nodes N..2N-1 are the leaves
  logic [NODES:1] up_w;
  logic [NODES:1] gnt_w;

  assign up_w[NODES:N] = req_i;
  assign gnt_w[1]      = up_w[1];
  assign gnt_o         = gnt_w[NODES:N];
  assign busy_o        = up_w[1];

  for (genvar i = 1; i < N; i++) begin : g_cell
    ntree_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_lo_i (up_w[2*i]),
      .req_hi_i (up_w[2*i+1]),
      .gnt_i    (gnt_w[i]),
      .req_o    (up_w[i]),
      .gnt_lo_o (gnt_w[2*i]),
      .gnt_hi_o (gnt_w[2*i+1])
    );
  end

  assert_grant_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_grant_to_requester_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  assert_grant_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(gnt_o) & req_i)) |-> (gnt_o == $past(gnt_o) && busy_o));

  assert_new_grant_needs_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(gnt_o & ~$past(gnt_o))) |-> (busy_o && !$past(busy_o)));

  assert_busy_covers_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> busy_o);

endmodule

// File: tb/ntree_arb_tb_top.sv
module ntree_arb_tb_top;

  localparam int N   = 8;
  localparam int LVL = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N-1:0] gnt;
  logic         busy;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ntree_arb #(.N(N)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .gnt_o  (gnt),
    .busy_o (busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock behavioural model of the legal grant set
  logic [N-1:0] prev_gnt;
  logic         prev_busy;
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      prev_gnt  = '0;
      prev_busy = 1'b0;
    end else begin
      chk($countones(gnt) <= 1, "R1 onehot", gnt, 0);
      chk((gnt & ~req) == 0, "R2 requester", gnt, req);
      chk(gnt == 0 || busy, "R9 busy", busy, 1);
      if ((prev_gnt & req) != 0) chk(gnt == prev_gnt && busy, "R3 hold", gnt, prev_gnt);
      if ((gnt & ~prev_gnt) != 0) chk(busy && !prev_busy, "R7 fresh", prev_busy, 0);
      prev_gnt  = gnt;
      prev_busy = busy;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    req   = '0;
    repeat (3) @(negedge clk);
    chk(gnt == 0, "R8 gnt", gnt, 0);
    chk(busy == 1'b0, "R8 busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_grant(output int leaf);
    int t = 0;
    while (gnt == 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    leaf = -1;
    if (gnt == 0) chk(1'b0, "watchdog", 0, 1);
    for (int j = 0; j < N; j++) if (gnt[j]) leaf = j;
  endtask

  task automatic contend(input logic [N-1:0] set, input logic [31:0] seq, input string tag);
    int leaf;
    do_reset();
    req = set;
    for (int k = 0; k < 8; k++) begin
      wait_grant(leaf);
      chk(leaf == int'(seq[4*k +: 4]), tag, leaf, seq[4*k +: 4]);
      if (leaf >= 0) begin
        req[leaf] = 1'b0;
        @(negedge clk);
        req[leaf] = 1'b1;
      end
    end
    req = '0;
    repeat (LVL + 2) @(negedge clk);
  endtask

  initial begin
    do_reset();

    // R5: single request from idle
    req = 8'h20;
    @(negedge clk);
    @(negedge clk);
    chk(gnt == 0, "R5 early", gnt, 0);
    @(negedge clk);
    chk(gnt == 8'h20, "R5 grant", gnt, 8'h20);
    chk(busy == 1'b1, "R5 busy", busy, 1);

    // R3: held while requested, others arriving are not served
    req = 8'h25;
    repeat (20) begin
      @(negedge clk);
      chk(gnt == 8'h20, "R3 held", gnt, 8'h20);
    end

    // R4: withdrawal
    req = 8'h05;
    #1;
    chk(gnt == 0, "R4 drop", gnt, 0);
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b1, "R4 unwind", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R4 idle", busy, 0);
    req = '0;
    repeat (4) @(negedge clk);

    contend(8'h81, 32'h70707070, "R6 root alternation");
    contend(8'h0C, 32'h32323232, "R6 sibling alternation");
    contend(8'h13, 32'h41404140, "R7 non-greedy order");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule